// File: doc/BRIEF.md
# Demultiplexed External SRAM Interface

This block is the glue between a bus master whose low address byte and data byte share one set of lines and an 8 KB asynchronous static RAM. The master puts the full address out while its E strobe is low. It drives the upper byte on a separate port and the lower byte on the shared lines. AS marks the lower byte as valid. When E goes high, the shared lines carry data. The interface holds the lower address in a level-sensitive latch that follows the shared lines while AS is high and freezes when AS falls. The RAM therefore sees a steady 13-bit address through the data half of the cycle.

The upper three address bits pick one of eight 8 KB windows. The RAM answers only in window 2 (addresses 0x4000 to 0x5FFF). The window select is gated by E, so the RAM chip select, output enable and write enable can only assert in the E-high half. The shared bus is a split input, output and output-enable triple. On a read, RAM data is placed on the output with the enable raised. On a write, the shared input lines are stored. A behavioural 8K x 8 array is part of the block so that the data path can be observed at the ports.

Top module: `muxbus_sram_bridge`

## Requirements
- R1: sram_addr_o[7:0] follows ad_i while as_i is high, and keeps the value present when as_i fell for as long as as_i stays low, even if ad_i changes.
- R2: sram_addr_o[12:8] always equals addr_hi_i[4:0].
- R3: sram_cs1_no is low exactly when e_i is high and addr_hi_i[7:5] equals 3'b010; otherwise it is high.
- R4: sram_cs2_o is always high.
- R5: sram_we_no is low exactly when e_i is high and rw_i is low (rw_i high means read).
- R6: sram_oe_no is low exactly when e_i is high, rw_i is high and addr_hi_i[7:5] equals 3'b010.
- R7: During a read data phase in the window, ad_oe_o is high and ad_o carries the stored byte at the latched 13-bit address.
- R8: A write data phase in the window stores ad_i at the 13-bit address. A later read of that address returns it.
- R9: An access outside the window changes no stored byte, including the byte whose low 13 address bits match, and leaves ad_oe_o low.
- R10: ad_oe_o is low whenever e_i is low, and is low during every write data phase.
- R11: While rst_ni is low the low address latch is cleared to 0x00. After reset with as_i low, sram_addr_o[7:0] stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the behavioural array's write port |
| rst_ni | input | 1 | Active-low asynchronous reset of the low address latch |
| e_i | input | 1 | Bus strobe: low is the address phase, high is the data phase |
| as_i | input | 1 | Address strobe; the low address latch is open while high |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_hi_i | input | 8 | Upper address byte |
| ad_i | input | 8 | Shared lines as driven by the master (low address, then write data) |
| ad_o | output | 8 | Read data toward the shared lines, zero when not driving |
| ad_oe_o | output | 1 | Drive enable for ad_o onto the shared lines |
| sram_addr_o | output | 13 | Demultiplexed RAM address |
| sram_cs1_no | output | 1 | Active-low RAM chip select from the window decode |
| sram_cs2_o | output | 1 | Active-high RAM chip select, held asserted |
| sram_we_no | output | 1 | Active-low RAM write enable |
| sram_oe_no | output | 1 | Active-low RAM output enable |

## Verification
The address, selects, enables and read data come from combinational paths, so every one is due in the same cycle as the input change that causes it. The bench drives on the falling clock edge and samples a quarter period after the next rising edge. A write is stored on the rising edge inside the E-high phase. Its effect is therefore checked only by a read in a later bus cycle. The scoreboard queues the expected read result when the data phase starts and compares it in that same phase.

// File: rtl/muxbus_sram_pkg.sv
package muxbus_sram_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned BLK_W   = 3;
  localparam int unsigned MEM_BLK = 2;

  typedef enum logic {
    BUS_WRITE = 1'b0,
    BUS_READ  = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/lo_addr_latch.sv
module lo_addr_latch #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_l;

  // transparent while le_i high, holds after it falls
  always_latch begin
    if (!rst_ni)   q_l = '0;
    else if (le_i) q_l = d_i;
  end

  assign q_o = q_l;
endmodule

// File: rtl/win_decoder.sv
module win_decoder #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned HIT   = 2
) (
  input  logic             en_i,
  input  logic             en_a_ni,
  input  logic             en_b_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_no
);
  localparam logic [SEL_W-1:0] HIT_CODE = SEL_W'(HIT);

  logic enabled;
  assign enabled = en_i & ~en_a_ni & ~en_b_ni;
  assign hit_no  = ~(enabled && (sel_i == HIT_CODE));
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import muxbus_sram_pkg::*;
(
  input  logic e_i,
  input  logic rw_i,
  input  logic cs_ni,
  output logic we_no,
  output logic oe_no
);
  logic is_read;
  assign is_read = (bus_dir_e'(rw_i) == BUS_READ);

  assign we_no = ~(e_i & ~is_read);
  assign oe_no = ~(e_i & is_read & ~cs_ni);
endmodule

// File: rtl/sram_model.sv
module sram_model #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  input  logic          cs1_ni,
  input  logic          cs2_i,
  input  logic          we_ni
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          sel;

  assign sel = ~cs1_ni & cs2_i;

  always_ff @(posedge clk_i) begin
    if (sel && !we_ni) mem[addr_i] <= din_i;
  end

  assign dout_o = mem[addr_i];
endmodule

// File: rtl/muxbus_sram_bridge.sv
module muxbus_sram_bridge
  import muxbus_sram_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned BW  = BLK_W,
  parameter int unsigned BLK = MEM_BLK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               e_i,
  input  logic               as_i,
  input  logic               rw_i,
  input  logic [AW-DW-1:0]   addr_hi_i,
  input  logic [DW-1:0]      ad_i,
  output logic [DW-1:0]      ad_o,
  output logic               ad_oe_o,
  output logic [AW-BW-1:0]   sram_addr_o,
  output logic               sram_cs1_no,
  output logic               sram_cs2_o,
  output logic               sram_we_no,
  output logic               sram_oe_no
);
  localparam int unsigned HI_W  = AW - DW;
  localparam int unsigned MEM_W = AW - BW;
  localparam int unsigned PASS_W = MEM_W - DW;

  logic [DW-1:0] lo_addr;
  logic [DW-1:0] rd_data;
  logic          cs_n;
  logic          we_n;
  logic          oe_n;

  lo_addr_latch #(.W(DW)) u_latch (
    .rst_ni (rst_ni),
    .le_i   (as_i),
    .d_i    (ad_i),
    .q_o    (lo_addr)
  );

  // partial decode on the top bits; E gates the active-high enable
  win_decoder #(.SEL_W(BW), .HIT(BLK)) u_dec (
    .en_i    (e_i),
    .en_a_ni (1'b0),
    .en_b_ni (1'b0),
    .sel_i   (addr_hi_i[HI_W-1 -: BW]),
    .hit_no  (cs_n)
  );

  strobe_gen u_strb (
    .e_i   (e_i),
    .rw_i  (rw_i),
    .cs_ni (cs_n),
    .we_no (we_n),
    .oe_no (oe_n)
  );

  sram_model #(.AW(MEM_W), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .addr_i (sram_addr_o),
    .din_i  (ad_i),
    .dout_o (rd_data),
    .cs1_ni (cs_n),
    .cs2_i  (sram_cs2_o),
    .we_ni  (we_n)
  );

  assign sram_addr_o = {addr_hi_i[PASS_W-1:0], lo_addr};
  assign sram_cs1_no = cs_n;
  assign sram_cs2_o  = 1'b1;
  assign sram_we_no  = we_n;
  assign sram_oe_no  = oe_n;
  assign ad_oe_o     = ~oe_n;
  assign ad_o        = oe_n ? '0 : rd_data;
endmodule

// File: rtl/muxbus_sram_bridge_chk.sv
module muxbus_sram_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        e_i,
  input logic        as_i,
  input logic        rw_i,
  input logic [7:0]  addr_hi_i,
  input logic        ad_oe_o,
  input logic [12:0] sram_addr_o,
  input logic        sram_cs1_no,
  input logic        sram_we_no,
  input logic        sram_oe_no
);
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_i && $past(!as_i)) |-> $stable(sram_addr_o[7:0])); // R1
  AST_CS_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_cs1_no |-> (e_i && addr_hi_i[7:5] == 3'b010)); // R3
  AST_WE_DATA_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (e_i && !rw_i)); // R5
  AST_OE_READ_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (rw_i && !sram_cs1_no)); // R6
  AST_NO_DRIVE_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !sram_cs1_no); // R9
  AST_NO_ADDR_CONTEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e_i || !rw_i) |-> !ad_oe_o); // R10
endmodule

bind muxbus_sram_bridge muxbus_sram_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .e_i         (e_i),
  .as_i        (as_i),
  .rw_i        (rw_i),
  .addr_hi_i   (addr_hi_i),
  .ad_oe_o     (ad_oe_o),
  .sram_addr_o (sram_addr_o),
  .sram_cs1_no (sram_cs1_no),
  .sram_we_no  (sram_we_no),
  .sram_oe_no  (sram_oe_no)
);

// File: tb/muxbus_sram_bridge_tb.sv
module muxbus_sram_bridge_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        e = 1'b0, as_s = 1'b0, rw = 1'b1;
  logic [7:0]  addr_hi = 8'h00, ad_in = 8'h00;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [12:0] sram_addr;
  logic        cs1_n, cs2, we_n, oe_n;

  typedef struct packed {
    logic        drive;
    logic [7:0]  data;
    logic [15:0] addr;
  } rd_exp_t;

  rd_exp_t     exp_q[$];
  rd_exp_t     cur;
  logic        rd_strobe = 1'b0;
  logic [7:0]  shadow [int];
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_sram_bridge u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .e_i         (e),
    .as_i        (as_s),
    .rw_i        (rw),
    .addr_hi_i   (addr_hi),
    .ad_i        (ad_in),
    .ad_o        (ad_out),
    .ad_oe_o     (ad_oe),
    .sram_addr_o (sram_addr),
    .sram_cs1_no (cs1_n),
    .sram_cs2_o  (cs2),
    .sram_we_no  (we_n),
    .sram_oe_no  (oe_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return a[15:13] == 3'b010;
  endfunction

  task automatic addr_phase(input logic [15:0] a, input logic r);
    @(negedge clk);
    e = 1'b0; as_s = 1'b1; rw = r; addr_hi = a[15:8]; ad_in = a[7:0];
    settle();
    chk(sram_addr[7:0] == a[7:0], "R1", "latch open", sram_addr[7:0], a[7:0]);
    chk(!ad_oe, "R10", "no drive in address phase", ad_oe, 0);
    chk(cs1_n, "R3", "select idle while E low", cs1_n, 1);
    @(negedge clk);
    as_s = 1'b0;
    @(negedge clk);
    ad_in = ~a[7:0];
    settle();
    chk(sram_addr[7:0] == a[7:0], "R1", "latch holds", sram_addr[7:0], a[7:0]);
  endtask

  task automatic data_checks(input logic [15:0] a, input logic r);
    chk(sram_addr == a[12:0], "R2", "ram address", sram_addr, a[12:0]);
    chk(cs1_n == !in_win(a), "R3", "window select", cs1_n, !in_win(a));
    chk(cs2, "R4", "high select", cs2, 1);
    chk(we_n == r, "R5", "write enable", we_n, r);
    chk(oe_n == !(r && in_win(a)), "R6", "output enable", oe_n, !(r && in_win(a)));
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    addr_phase(a, 1'b0);
    @(negedge clk);
    e = 1'b1; ad_in = d;
    settle();
    data_checks(a, 1'b0);
    chk(!ad_oe, "R10", "no drive on write", ad_oe, 0);
    if (in_win(a)) shadow[int'(a[12:0])] = d;
    @(negedge clk);
    e = 1'b0; rw = 1'b1;
  endtask

  task automatic bus_read(input logic [15:0] a);
    rd_exp_t x;
    addr_phase(a, 1'b1);
    @(negedge clk);
    e = 1'b1; ad_in = 8'h5A;
    x.drive = in_win(a);
    x.data  = shadow.exists(int'(a[12:0])) ? shadow[int'(a[12:0])] : 8'h00;
    x.addr  = a;
    exp_q.push_back(x);
    rd_strobe = 1'b1;
    settle();
    data_checks(a, 1'b1);
    @(negedge clk);
    rd_strobe = 1'b0; e = 1'b0;
  endtask

  // monitor: compares the read data phase against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rd_strobe && exp_q.size() > 0) begin
        cur = exp_q.pop_front();
        chk(ad_oe == cur.drive, cur.drive ? "R7" : "R9", "bus drive",
            ad_oe, cur.drive);
        if (cur.drive)
          chk(ad_out == cur.data, "R8", "read data", ad_out, cur.data);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    ad_in = 8'hA5;
    repeat (3) @(negedge clk);
    #1;
    chk(sram_addr[7:0] == 8'h00, "R11", "latch cleared in reset", sram_addr[7:0], 0);
    chk(cs2, "R4", "high select in reset", cs2, 1);
    chk(we_n && oe_n && cs1_n, "R5", "strobes idle", {we_n, oe_n, cs1_n}, 3'b111);
    chk(!ad_oe, "R10", "bus idle", ad_oe, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    settle();
    chk(sram_addr[7:0] == 8'h00, "R11", "latch after reset", sram_addr[7:0], 0);

    bus_write(16'h4000, 8'h3C);
    bus_write(16'h5FFF, 8'hC3);
    bus_write(16'h4100, 8'h11);
    bus_write(16'h4ABC, 8'h5E);
    bus_write(16'h2100, 8'hEE);   // R9: aliases 0x4100 in the low 13 bits
    bus_write(16'h6100, 8'h77);   // R9
    bus_write(16'h3FFF, 8'h99);   // R9: aliases 0x5FFF
    bus_read(16'h4000);
    bus_read(16'h5FFF);
    bus_read(16'h4100);
    bus_read(16'h4ABC);
    bus_read(16'h2100);
    bus_read(16'h6000);
    bus_read(16'h3FFF);
    bus_read(16'hE100);
    for (int i = 0; i < 16; i++)
      bus_write(16'h4200 + 16'(i * 17), 8'(i * 13 + 7));
    for (int i = 15; i >= 0; i--)
      bus_read(16'h4200 + 16'(i * 17));
    bus_write(16'h4000, 8'hA0);
    bus_read(16'h4000);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule